// File: doc/BRIEF.md
# Signed 16-bit integer to 23-bit floating-point converter

This block turns a signed two's-complement integer into a compact 23-bit floating-point word. The word has a single sign bit, a 7-bit exponent stored with an offset of 63, and a 15-bit fraction whose leading one is implied rather than stored. Every 16-bit integer needs at most 16 significant bits, and the hidden one plus 15 fraction bits hold exactly that many, so each conversion is exact and no rounding logic exists.

A sample is offered with a qualifier strobe. The block forms the absolute value and locates its highest set bit with a priority encoder. The exponent is the offset plus that bit index. The magnitude is then shifted up until that bit sits just above the fraction field, where it is dropped. The result is registered, so it appears one clock after the sample with a matching strobe. A new sample may be offered on every cycle.

Top module: `i2f_convert`

## Requirements
- R1: The output word places the sign in bit 22, the exponent field in bits 21 down to 15 and the stored fraction in bits 14 down to 0. For example, +1 encodes as 0x1F8000, -1 as 0x5F8000, +2 as 0x200000, +4 as 0x208000 and +3 as 0x204000.
- R2: An input of zero produces an output word of all zeros.
- R3: For any non-zero input, bit 22 of the result is 1 exactly when the input is negative (input bit 15 set).
- R4: For a non-zero input, the exponent field equals 63 plus the bit index of the highest set bit of the input's absolute value.
- R5: For a non-zero input, the fraction field holds the absolute-value bits below its highest set bit, left-aligned so that the bit just below the leading one lands in bit 14, with zeros filling the vacated low bits.
- R6: The most negative input, -32768 (0x8000), is treated as magnitude 32768 and encodes as 0x670000.
- R7: `out_valid` equals the value `in_valid` had one clock earlier, and the result word for a sample accepted at one clock edge is present after the next.
- R8: While `rst` is high at a clock edge, `out_valid` and `out_data` are cleared to zero.
- R9: On a clock edge where `in_valid` is low, `out_data` keeps its previous value, whatever `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` on this edge |
| in_data | input | 16 | Signed two's-complement integer to convert |
| out_valid | output | 1 | Qualifies `out_data`; one clock behind `in_valid` |
| out_data | output | 23 | Encoded float: sign, exponent, fraction |

## Verification
Two things happen in the same cycle while streaming: the output register presents the result for the previous sample, and the conversion logic captures the next sample. The bench provokes this by offering every one of the 65536 input codes back to back, with the strobe held high throughout. At each clock it compares the presented word with an arithmetic encoding of the sample offered one clock earlier. Any leak of the incoming sample into the presented result, or any slip of one cycle, shows up as a mismatch.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int unsigned I2F_IN_W   = 16;
  localparam int unsigned I2F_EXP_W  = 7;
  localparam int unsigned I2F_FRAC_W = 15;
  localparam int unsigned I2F_BIAS   = 63;
endpackage

// File: rtl/i2f_magnitude.sv
module i2f_magnitude #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] value,
  output logic         neg,
  output logic [W-1:0] mag
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    neg = value[W-1];
    mag = neg ? ((~value) + ONE) : value;
  end
endmodule

// File: rtl/i2f_lead_one.sv
module i2f_lead_one #(
  parameter int unsigned W  = 16,
  parameter int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  logic [W-1:0] hi_any;
  logic [W-1:0] lead;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign hi_any[i] = 1'b0;
    end else begin : g_rest
      assign hi_any[i] = hi_any[i+1] | vec[i+1];
    end
    assign lead[i] = vec[i] & ~hi_any[i];
  end

  always_comb begin
    pos   = '0;
    found = |vec;
    for (int i = 0; i < W; i++) begin
      if (lead[i]) pos = pos | PW'(i);
    end
  end
endmodule

// File: rtl/i2f_normalize.sv
module i2f_normalize #(
  parameter int unsigned W      = 16,
  parameter int unsigned PW     = $clog2(W),
  parameter int unsigned EXP_W  = 7,
  parameter int unsigned FRAC_W = 15,
  parameter int unsigned BIAS   = 63
) (
  input  logic [W-1:0]      mag,
  input  logic [PW-1:0]     pos,
  output logic [EXP_W-1:0]  exp_f,
  output logic [FRAC_W-1:0] frac_f
);
  localparam int unsigned NORM_W = FRAC_W + 1;
  localparam int unsigned PAD    = NORM_W - W;

  logic [NORM_W-1:0] ext;
  logic [NORM_W-1:0] norm;
  logic [PW-1:0]     shamt;

  if (PAD > 0) begin : g_pad
    assign ext = {mag, {PAD{1'b0}}};
  end else begin : g_nopad
    assign ext = mag;
  end

  always_comb begin
    shamt  = PW'(W - 1) - pos;
    norm   = ext << shamt;
    frac_f = norm[FRAC_W-1:0];
    exp_f  = EXP_W'(BIAS) + EXP_W'(pos);
  end

  // R5
  always_comb begin
    if (|mag) begin
      lead_aligned_chk: assert (norm[NORM_W-1]);
    end
  end
endmodule

// File: rtl/i2f_convert.sv
module i2f_convert #(
  parameter int unsigned IN_W   = i2f_pkg::I2F_IN_W,
  parameter int unsigned EXP_W  = i2f_pkg::I2F_EXP_W,
  parameter int unsigned FRAC_W = i2f_pkg::I2F_FRAC_W,
  parameter int unsigned BIAS   = i2f_pkg::I2F_BIAS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [IN_W-1:0]           in_data,
  output logic                      out_valid,
  output logic [EXP_W+FRAC_W:0]     out_data
);
  localparam int unsigned OUT_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned POS_W = $clog2(IN_W);

  logic              neg;
  logic [IN_W-1:0]   mag;
  logic [POS_W-1:0]  pos;
  logic              found;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [OUT_W-1:0]  word;

  i2f_magnitude #(.W(IN_W)) u_mag (
    .value(in_data), .neg(neg), .mag(mag)
  );

  i2f_lead_one #(.W(IN_W), .PW(POS_W)) u_lead (
    .vec(mag), .pos(pos), .found(found)
  );

  i2f_normalize #(
    .W(IN_W), .PW(POS_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)
  ) u_norm (
    .mag(mag), .pos(pos), .exp_f(exp_f), .frac_f(frac_f)
  );

  assign word = found ? {neg, exp_f, frac_f} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= word;
    end
  end

  // R7
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R2
  zero_word_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == '0) |=> (out_data == '0));

  // R3
  sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data != '0) |=> (out_data[OUT_W-1] == $past(in_data[IN_W-1])));
endmodule

// File: tb/test_i2f_convert.sv
module test_i2f_convert;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [22:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  i2f_convert i_i2f_convert (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [22:0] ref_enc(input int v);
    int m;
    int p;
    int e;
    int f;
    m = (v < 0) ? -v : v;
    if (m == 0) return 23'h0;
    p = 0;
    for (int b = 0; b < 17; b++) if (m >= (1 << b)) p = b;
    e = 63 + p;
    f = (m - (1 << p)) << (15 - p);
    return {(v < 0) ? 1'b1 : 1'b0, 7'(e), 15'(f)};
  endfunction

  task automatic chk(input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%06h expected 0x%06h", req, act, exp);
    end
  endtask

  task automatic one(input int v, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'(v);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, out_data, ref_enc(v));
    chk({req, " valid"}, {22'h0, out_valid}, 23'h1);
  endtask

  initial begin
    logic [22:0] held;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 data", out_data, 23'h0);
    chk("R8 valid", {22'h0, out_valid}, 23'h0);
    rst = 1'b0;

    // R1: fixed encodings
    one(1, "R1 +1");   chk("R1 +1 const", out_data, 23'h1F8000);
    one(-1, "R1 -1");  chk("R1 -1 const", out_data, 23'h5F8000);
    one(2, "R1 +2");   chk("R1 +2 const", out_data, 23'h200000);
    one(4, "R1 +4");   chk("R1 +4 const", out_data, 23'h208000);
    one(3, "R1 +3");   chk("R1 +3 const", out_data, 23'h204000);
    // R6: most negative input
    one(-32768, "R6"); chk("R6 const", out_data, 23'h670000);
    // R2: zero after a non-zero word
    one(0, "R2");      chk("R2 const", out_data, 23'h0);
    // R3: sign on small and large negatives
    one(-5, "R3 -5");  chk("R3 sign", {22'h0, out_data[22]}, 23'h1);
    one(32767, "R3 max"); chk("R3 pos sign", {22'h0, out_data[22]}, 23'h0);

    // R9 and R7: idle cycles ignore in_data
    held = out_data;
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = 16'h1234;
    @(negedge clk);
    chk("R9 hold", out_data, held);
    chk("R7 idle valid", {22'h0, out_valid}, 23'h0);
    in_data = 16'hFFFF;
    @(negedge clk);
    chk("R9 hold again", out_data, held);

    // R4 R5 R7: back-to-back exhaustive sweep
    for (int i = 0; i <= 65536; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R4/R5 sweep", out_data, ref_enc(int'($signed(16'(i - 1)))));
        if (out_valid !== 1'b1) begin
          checks++; fails++;
          $display("FAIL R7 streaming valid: actual %b expected 1", out_valid);
        end
      end
      if (i < 65536) begin
        in_valid = 1'b1;
        in_data  = 16'(i);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R7 drop", {22'h0, out_valid}, 23'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule